// File: doc/BRIEF.md
# Card Initialisation Clock Sequencer

This block runs the short handshake that a memory-card host performs when the slot is powered on. Before the card can take its first command, the host must send a stream of initialisation clocks. The host does this by putting its controller into an init mode and posting a command write that carries zero data. It then polls for command-complete, takes the controller out of init mode and acknowledges the status flag by writing a 1 to clear it. The host interrupt line stays masked for the whole exchange, so the artificial command-complete never reaches software.

The block fires only when a power-mode request marks a change into the power-on state. A request that repeats the previous mode does nothing, and so does a request for any other mode. The wait for command-complete is bounded by a count of timer ticks. If that count runs out, the sequence is abandoned: init mode and the interrupt mask are left as they are, and a sticky flag records the event. Generating the clock on the card bus belongs to the surrounding controller.

Top module: `cinit_seq`

## Requirements
- R1: After reset the previous-mode register holds an undefined encoding (3), so the first power-on request always starts a sequence.
- R2: A request for the same mode as the last accepted request causes no output activity.
- R3: A request for power-off (0) or power-up (1) causes no output activity but becomes the new previous mode. Only power-on (2) following a different mode starts a sequence.
- R4: One cycle after the start request is sampled, `irq_mask` and `busy` are high. One cycle later `init_bit` is high and `cmd_wr` pulses for exactly one cycle with `cmd_wdata` equal to zero.
- R5: The command-complete level is examined only after the command write. A cycle with `cc_status` high in the wait phase clears `init_bit` at the next edge. That same edge starts a one-cycle `stat_clr` pulse whose `stat_wdata` has only bit 0 set.
- R6: The edge after the `stat_clr` cycle drops `irq_mask` and `busy` and raises `done` for exactly one cycle. `irq_mask` stays high for the whole sequence.
- R7: If `cc_status` is not seen within TMO_TICKS tick pulses of the wait phase, the sequence ends with `init_bit` and `irq_mask` still high and with no `stat_clr` or `done`.
- R8: `timeout_flag` rises on a timeout and stays high until reset, including across later successful sequences.
- R9: Wait cycles with `tick` low do not advance the timeout count.
- R10: Power-mode requests presented while `busy` is high are ignored and do not change the previous mode.
- R11: Reset clears `init_bit`, `irq_mask`, `busy`, `cmd_wr`, `stat_clr`, `done` and `timeout_flag`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_req_vld | input | 1 | Power-mode request strobe |
| pwr_req | input | 2 | Requested mode: 0 off, 1 up, 2 on |
| cc_status | input | 1 | Command-complete status level |
| tick | input | 1 | Timer tick that advances the timeout count |
| init_bit | output | 1 | Init-mode control bit |
| cmd_wr | output | 1 | Dummy command-write strobe |
| cmd_wdata | output | CMD_W | Command write data, always zero |
| stat_clr | output | 1 | Status write-1-to-clear strobe |
| stat_wdata | output | STAT_W | Status write data, only the complete bit set |
| irq_mask | output | 1 | Host interrupt mask |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle normal-completion pulse |
| timeout_flag | output | 1 | Sticky timeout indication |

## Verification
A lost or corrupted previous-mode value shows up on the very next request. A repeated power-on would raise `irq_mask` one cycle later, or a genuine edge into power-on would stay silent. A state machine stuck or skipping a step shows within one to two cycles, as a missing or doubled `cmd_wr`, as `stat_clr` while `init_bit` is still high, or as `done` without the unmask. A timeout counter that is off by one or ignores `tick` moves the cycle in which `busy` falls relative to the tick count, so the edges just before and just after expiry are sampled.

// File: rtl/cinit_pkg.sv
package cinit_pkg;

  typedef enum logic [1:0] {
    PWR_OFF   = 2'd0,
    PWR_UP    = 2'd1,
    PWR_ON    = 2'd2,
    PWR_UNDEF = 2'd3
  } pwr_mode_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ARM,
    S_ISSUE,
    S_WAIT,
    S_ACK
  } seq_state_e;

  // True when a request marks a change into the power-on state.
  function automatic logic enters_power_on(pwr_mode_e req, pwr_mode_e prev);
    return (req == PWR_ON) && (prev != PWR_ON);
  endfunction

  // Single-bit write-1-to-clear word for a status flag position.
  function automatic logic [31:0] flag_word(int unsigned pos);
    return 32'd1 << pos;
  endfunction

endpackage

// File: rtl/cinit_mode_track.sv
module cinit_mode_track
  import cinit_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      req_vld,
  input  pwr_mode_e req_mode,
  input  logic      accept,
  output logic      start
);

  pwr_mode_e prev_mode;
  logic      taken;

  assign taken = req_vld && accept;
  assign start = taken && enters_power_on(req_mode, prev_mode);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_mode <= PWR_UNDEF;
    end else if (taken) begin
      prev_mode <= req_mode;
    end
  end

  AST_NO_REPEAT_START: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !start); // R2

endmodule

// File: rtl/cinit_wait_timer.sv
module cinit_wait_timer #(
  parameter int LIMIT = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic run,
  input  logic tick,
  output logic expired
);

  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  assign expired = run && tick && (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (arm) begin
      cnt <= '0;
    end else if (run && tick && !expired) begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(LIMIT)); // R7

  AST_TICK_GATES_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick && !arm) |=> $stable(cnt)); // R9

endmodule

// File: rtl/cinit_seq_fsm.sv
module cinit_seq_fsm
  import cinit_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic cc_seen,
  input  logic expired,
  output logic busy,
  output logic init_q,
  output logic mask_q,
  output logic cmd_wr,
  output logic stat_clr,
  output logic done_q,
  output logic tmo_q,
  output logic timer_arm,
  output logic timer_run
);

  seq_state_e state, state_nx;
  logic init_nx, mask_nx, done_nx, tmo_nx;

  assign busy      = (state != S_IDLE);
  assign cmd_wr    = (state == S_ISSUE);
  assign stat_clr  = (state == S_ACK);
  assign timer_arm = (state == S_ISSUE);
  assign timer_run = (state == S_WAIT);

  always_comb begin
    state_nx = state;
    init_nx  = init_q;
    mask_nx  = mask_q;
    done_nx  = 1'b0;
    tmo_nx   = tmo_q;
    unique case (state)
      S_IDLE: begin
        if (start) begin
          mask_nx  = 1'b1;
          state_nx = S_ARM;
        end
      end
      S_ARM: begin
        init_nx  = 1'b1;
        state_nx = S_ISSUE;
      end
      S_ISSUE: state_nx = S_WAIT;
      S_WAIT: begin
        if (cc_seen) begin
          init_nx  = 1'b0;
          state_nx = S_ACK;
        end else if (expired) begin
          tmo_nx   = 1'b1;
          state_nx = S_IDLE;
        end
      end
      S_ACK: begin
        mask_nx  = 1'b0;
        done_nx  = 1'b1;
        state_nx = S_IDLE;
      end
      default: state_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      init_q <= 1'b0;
      mask_q <= 1'b0;
      done_q <= 1'b0;
      tmo_q  <= 1'b0;
    end else begin
      state  <= state_nx;
      init_q <= init_nx;
      mask_q <= mask_nx;
      done_q <= done_nx;
      tmo_q  <= tmo_nx;
    end
  end

  AST_CMD_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> !cmd_wr); // R4

  AST_CMD_UNDER_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |-> init_q); // R4

  AST_MASK_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> mask_q); // R6

  AST_TMO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(tmo_q) |-> tmo_q); // R8

  AST_TMO_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_q) |-> (init_q && mask_q && !busy)); // R7

endmodule

// File: rtl/cinit_seq.sv
module cinit_seq
  import cinit_pkg::*;
#(
  parameter int CMD_W     = 32,
  parameter int STAT_W    = 32,
  parameter int CC_BIT    = 0,
  parameter int TMO_TICKS = 250000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_req_vld,
  input  logic [1:0]        pwr_req,
  input  logic              cc_status,
  input  logic              tick,
  output logic              init_bit,
  output logic              cmd_wr,
  output logic [CMD_W-1:0]  cmd_wdata,
  output logic              stat_clr,
  output logic [STAT_W-1:0] stat_wdata,
  output logic              irq_mask,
  output logic              busy,
  output logic              done,
  output logic              timeout_flag
);

  // Named internal events
  logic start_evt;
  logic expire_evt;
  logic timer_arm;
  logic timer_run;

  cinit_mode_track u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_vld  (pwr_req_vld),
    .req_mode (pwr_mode_e'(pwr_req)),
    .accept   (!busy),
    .start    (start_evt)
  );

  cinit_wait_timer #(.LIMIT(TMO_TICKS)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm     (timer_arm),
    .run     (timer_run),
    .tick    (tick),
    .expired (expire_evt)
  );

  cinit_seq_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start_evt),
    .cc_seen   (cc_status),
    .expired   (expire_evt),
    .busy      (busy),
    .init_q    (init_bit),
    .mask_q    (irq_mask),
    .cmd_wr    (cmd_wr),
    .stat_clr  (stat_clr),
    .done_q    (done),
    .tmo_q     (timeout_flag),
    .timer_arm (timer_arm),
    .timer_run (timer_run)
  );

  assign cmd_wdata  = '0;
  assign stat_wdata = STAT_W'(flag_word(CC_BIT));

  AST_START_NEEDS_ON: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(pwr_req_vld && (pwr_req == PWR_ON))); // R3

  AST_ACK_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    stat_clr |-> (!init_bit && irq_mask)); // R5

  AST_DONE_FOLLOWS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(stat_clr) && !irq_mask && !busy)); // R6

  AST_NO_ACK_ON_TMO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_flag) |-> (!stat_clr && !done)); // R7

endmodule

// File: tb/test_cinit_seq.sv
module test_cinit_seq;

  localparam int TMO = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        pwr_req_vld;
  logic [1:0]  pwr_req;
  logic        cc_status;
  logic        tick;
  logic        init_bit, cmd_wr, stat_clr, irq_mask, busy, done, timeout_flag;
  logic [31:0] cmd_wdata, stat_wdata;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  cinit_seq #(.CMD_W(32), .STAT_W(32), .CC_BIT(0), .TMO_TICKS(TMO)) i_cinit_seq (
    .clk(clk), .rst_n(rst_n), .pwr_req_vld(pwr_req_vld), .pwr_req(pwr_req),
    .cc_status(cc_status), .tick(tick), .init_bit(init_bit), .cmd_wr(cmd_wr),
    .cmd_wdata(cmd_wdata), .stat_clr(stat_clr), .stat_wdata(stat_wdata),
    .irq_mask(irq_mask), .busy(busy), .done(done), .timeout_flag(timeout_flag)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Present one request; returns at the negedge after it was sampled.
  task automatic send_req(logic [1:0] mode);
    @(negedge clk);
    pwr_req_vld = 1'b1;
    pwr_req     = mode;
    @(negedge clk);
    pwr_req_vld = 1'b0;
  endtask

  task automatic expect_quiet(string tag, logic exp_init, logic exp_mask);
    for (int i = 0; i < 3; i++) begin
      chk({tag, " busy"}, busy, 0);
      chk({tag, " cmd_wr"}, cmd_wr, 0);
      chk({tag, " init"}, init_bit, exp_init);
      chk({tag, " mask"}, irq_mask, exp_mask);
      @(negedge clk);
    end
  endtask

  // Called right after send_req(ON); ends in the first wait-phase cycle.
  task automatic expect_start(string tag, logic init_before);
    chk({tag, " R4 busy"}, busy, 1);
    chk({tag, " R4 mask"}, irq_mask, 1);
    chk({tag, " R4 init early"}, init_bit, init_before);
    chk({tag, " R4 no cmd yet"}, cmd_wr, 0);
    @(negedge clk);
    chk({tag, " R4 init set"}, init_bit, 1);
    chk({tag, " R4 cmd_wr"}, cmd_wr, 1);
    chk({tag, " R4 cmd data"}, cmd_wdata, 0);
    chk({tag, " R5 no ack"}, stat_clr, 0);
    @(negedge clk);
    chk({tag, " R4 cmd one shot"}, cmd_wr, 0);
    chk({tag, " R5 waiting"}, busy, 1);
  endtask

  task automatic finish_ok(string tag);
    cc_status = 1'b1;
    @(negedge clk);
    chk({tag, " R5 stat_clr"}, stat_clr, 1);
    chk({tag, " R5 stat data"}, stat_wdata, 32'h1);
    chk({tag, " R5 init cleared"}, init_bit, 0);
    chk({tag, " R6 mask held"}, irq_mask, 1);
    chk({tag, " R6 no done yet"}, done, 0);
    cc_status = 1'b0;
    @(negedge clk);
    chk({tag, " R5 ack one shot"}, stat_clr, 0);
    chk({tag, " R6 unmask"}, irq_mask, 0);
    chk({tag, " R6 done"}, done, 1);
    chk({tag, " R6 idle"}, busy, 0);
    @(negedge clk);
    chk({tag, " R6 done pulse"}, done, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; pwr_req_vld = 1'b0; pwr_req = 2'd0; cc_status = 1'b0; tick = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 init", init_bit, 0);
    chk("R11 mask", irq_mask, 0);
    chk("R11 busy", busy, 0);
    chk("R11 cmd", cmd_wr, 0);
    chk("R11 ack", stat_clr, 0);
    chk("R11 done", done, 0);
    chk("R11 tmo", timeout_flag, 0);
  endtask

  task automatic t_first_on();
    send_req(2'd2);
    expect_start("R1 first", 1'b0);
    repeat (3) begin
      chk("R5 still waiting", busy, 1);
      @(negedge clk);
    end
    finish_ok("R1 first");
  endtask

  task automatic t_repeat_on();
    send_req(2'd2);
    expect_quiet("R2 repeat", 1'b0, 1'b0);
  endtask

  task automatic t_other_modes();
    send_req(2'd0);
    expect_quiet("R3 off", 1'b0, 1'b0);
    send_req(2'd1);
    expect_quiet("R3 up", 1'b0, 1'b0);
    cc_status = 1'b1;
    send_req(2'd2);
    expect_start("R3 early cc", 1'b0);
    finish_ok("R3 early cc");
  endtask

  task automatic t_busy_ignore();
    send_req(2'd0);
    send_req(2'd2);
    expect_start("R10 run", 1'b0);
    send_req(2'd0);
    chk("R10 still busy", busy, 1);
    finish_ok("R10 run");
    send_req(2'd2);
    expect_quiet("R10 prev kept", 1'b0, 1'b0);
  endtask

  task automatic t_tick_gate();
    send_req(2'd0);
    send_req(2'd2);
    expect_start("R9 run", 1'b0);
    tick = 1'b0;
    repeat (3 * TMO) @(negedge clk);
    chk("R9 no expiry busy", busy, 1);
    chk("R9 no expiry flag", timeout_flag, 0);
    tick = 1'b1;
    finish_ok("R9 run");
  endtask

  task automatic t_timeout();
    send_req(2'd0);
    send_req(2'd2);
    expect_start("R7 run", 1'b0);
    repeat (TMO - 1) @(negedge clk);
    chk("R7 before expiry busy", busy, 1);
    chk("R7 before expiry flag", timeout_flag, 0);
    @(negedge clk);
    chk("R7 abandoned", busy, 0);
    chk("R8 flag set", timeout_flag, 1);
    chk("R7 init kept", init_bit, 1);
    chk("R7 mask kept", irq_mask, 1);
    chk("R7 no ack", stat_clr, 0);
    chk("R7 no done", done, 0);
    @(negedge clk);
    chk("R7 no late done", done, 0);
  endtask

  task automatic t_recover();
    send_req(2'd0);
    expect_quiet("R7 state retained", 1'b1, 1'b1);
    send_req(2'd2);
    expect_start("R8 rerun", 1'b1);
    finish_ok("R8 rerun");
    chk("R8 flag sticky", timeout_flag, 1);
  endtask

  initial begin
    t_reset();
    t_first_on();
    t_repeat_on();
    t_other_modes();
    t_busy_ignore();
    t_tick_gate();
    t_timeout();
    t_recover();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL WATCHDOG: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule